// File: doc/BRIEF.md
# Dual-Port Predecoded Row Select

This block turns a row address into a one-hot word-line vector for each of the two ports of a dual-port memory array of 256 rows by 72 bits. The ports are fully separate. Each port has its own address, its own enable and its own precharge phase input, and it drives its own 256-bit word-line bus. The two ports never interact. Both may open the same row in the same cycle, and the block does not arbitrate between them.

Each port splits its row address into 2-bit fields. Every field is predecoded into a group of four mutually exclusive lines, and those groups are held in registers. A row's word line is the AND of one line taken from each group. To give the extra "no row" outcome, all four lines of a single group, the one that carries the two lowest address bits, are forced low. This happens while the port is precharging its bit lines or while the port is disabled. Because no row gate then has a full set of inputs, every word line of that port stays low.

The word lines follow the address by one clock. The top of the block repeats the same port structure for both ports through a generate loop.

Top module: `dp_row_decoder`

## Requirements
- R1: While the active-low reset is asserted, all 256 word lines of both ports are low.
- R2: If a port samples enable high and precharge low on a rising edge, then from that edge until the next one exactly one of its word lines is high, and that line's index equals the address sampled on that edge.
- R3: If a port samples precharge high on a rising edge, all of its word lines are low for the following cycle, whatever the enable and the address.
- R4: If a port samples enable low on a rising edge, all of its word lines are low for the following cycle, whatever the address.
- R5: The address is read as four 2-bit fields. Field k is address bits [2k+1:2k]. Word line i rises only when every field of the address equals the matching field of i. This holds for all 256 addresses on each port.
- R6: No port ever has more than one word line high.
- R7: The ports are independent. Each port's word lines depend only on that port's own inputs, and both ports may select the same row in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_a | input | 8 | Row address, port A |
| en_a | input | 1 | Port A enable (1 = may select a row) |
| pchg_a | input | 1 | Port A precharge phase (1 = no row selected) |
| wl_a | output | 256 | Port A word lines, one-hot or all zero |
| addr_b | input | 8 | Row address, port B |
| en_b | input | 1 | Port B enable (1 = may select a row) |
| pchg_b | input | 1 | Port B precharge phase (1 = no row selected) |
| wl_b | output | 256 | Port B word lines, one-hot or all zero |

## Verification
The hardest case to reach from the ports is a collision. In that case both ports are active on the same row in the same cycle, or one port precharges while the other reads the row it just left. A plain sweep of both addresses never produces either case. The stimulus therefore adds a phase that drives equal addresses on both ports. It also adds a phase in which precharge and enable are toggled on one port at a time while the other port keeps selecting rows. These phases run alongside a full 256-address sweep, in opposite directions on the two ports, and a random mix of all input combinations.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

   // Value of 2-bit-style field f (width fw) taken from a row index.
   function automatic int unsigned field_of(input int unsigned row,
                                            input int unsigned f,
                                            input int unsigned fw);
      return (row >> (f * fw)) & ((32'd1 << fw) - 32'd1);
   endfunction

   // Number of predecode groups needed for a given address width.
   function automatic int unsigned group_count(input int unsigned aw,
                                               input int unsigned fw);
      return aw / fw;
   endfunction

endpackage

// File: rtl/rowdec_field_predec.sv
module rowdec_field_predec #(
   parameter int FW = 2,
   parameter int GW = 1 << FW
) (
   input  logic [FW-1:0] field_i,
   input  logic          kill_i,
   output logic [GW-1:0] line_o
);

   if (GW != (1 << FW)) begin : g_bad_gw
      $error("rowdec_field_predec: GW must equal 2**FW");
   end

   always_comb begin
      line_o = '0;
      if (!kill_i) begin
         line_o[field_i] = 1'b1;
      end
   end

endmodule

// File: rtl/rowdec_and_plane.sv
module rowdec_and_plane
   import rowdec_pkg::*;
#(
   parameter int FW = 2,
   parameter int NF = 4,
   parameter int GW = 1 << FW,
   parameter int NR = 1 << (FW * NF)
) (
   input  logic [NF-1:0][GW-1:0] grp_i,
   output logic [NR-1:0]         wl_o
);

   // Each row gate takes exactly one line from every group.
   always_comb begin
      for (int i = 0; i < NR; i++) begin
         logic hit;
         hit = 1'b1;
         for (int f = 0; f < NF; f++) begin
            hit = hit & grp_i[f][FW'(field_of(i, f, FW))];
         end
         wl_o[i] = hit;
      end
   end

endmodule

// File: rtl/rowdec_port.sv
module rowdec_port
   import rowdec_pkg::*;
#(
   parameter int AW          = 8,
   parameter int FW          = 2,
   parameter int GATED_FIELD = 0,
   localparam int NF = AW / FW,
   localparam int GW = 1 << FW,
   localparam int NR = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          en_i,
   input  logic          pchg_i,
   output logic [NR-1:0] wl_o
);

   logic                  idle;
   logic [NF-1:0][GW-1:0] grp_d;
   logic [NF-1:0][GW-1:0] grp_q;

   assign idle = pchg_i | ~en_i;

   for (genvar f = 0; f < NF; f++) begin : g_field
      logic kill;
      if (f == GATED_FIELD) begin : g_gated
         assign kill = idle;
      end else begin : g_free
         assign kill = 1'b0;
      end

      rowdec_field_predec #(.FW(FW), .GW(GW)) u_predec (
         .field_i (addr_i[f*FW +: FW]),
         .kill_i  (kill),
         .line_o  (grp_d[f])
      );

      // R5: groups that are never gated are one-hot once loaded
      if (f != GATED_FIELD) begin : g_chk
         p_live_grp_r5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> $onehot(grp_q[f]));
      end
      p_grp_onehot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(grp_q[f]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q <= '0;
      end else begin
         grp_q <= grp_d;
      end
   end

   rowdec_and_plane #(.FW(FW), .NF(NF), .GW(GW), .NR(NR)) u_plane (
      .grp_i (grp_q),
      .wl_o  (wl_o)
   );

   // R1: reset leaves every word line low
   always @(negedge clk) begin
      if (!rst_n) begin
         p_rst_clear_r1: assert (wl_o == '0);
      end
   end

   p_row_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !pchg_i) |=> ($onehot(wl_o) && wl_o[$past(addr_i)]));

   p_pchg_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pchg_i |=> (wl_o == '0));

   p_dis_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (wl_o == '0));

   p_wl_onehot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wl_o));

endmodule

// File: rtl/dp_row_decoder.sv
module dp_row_decoder
   import rowdec_pkg::*;
#(
   parameter int AW          = 8,
   parameter int FW          = 2,
   parameter int GATED_FIELD = 0,
   localparam int NF = AW / FW,
   localparam int NR = 1 << AW,
   localparam int NP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_a,
   input  logic          en_a,
   input  logic          pchg_a,
   output logic [NR-1:0] wl_a,
   input  logic [AW-1:0] addr_b,
   input  logic          en_b,
   input  logic          pchg_b,
   output logic [NR-1:0] wl_b
);

   if (AW % FW != 0) begin : g_bad_split
      $error("dp_row_decoder: AW must be a multiple of FW");
   end
   if (GATED_FIELD < 0 || GATED_FIELD >= int'(group_count(AW, FW))) begin : g_bad_gate
      $error("dp_row_decoder: GATED_FIELD out of range");
   end
   if (AW > 12) begin : g_bad_size
      $error("dp_row_decoder: AW above 12 gives an oversized row plane");
   end

   logic [NP-1:0][AW-1:0] addr_p;
   logic [NP-1:0]         en_p;
   logic [NP-1:0]         pchg_p;
   logic [NP-1:0][NR-1:0] wl_p;

   assign addr_p = {addr_b, addr_a};
   assign en_p   = {en_b, en_a};
   assign pchg_p = {pchg_b, pchg_a};
   assign wl_a   = wl_p[0];
   assign wl_b   = wl_p[1];

   // R7: each port is a separate, identical decoder with no shared state
   for (genvar p = 0; p < NP; p++) begin : g_port
      rowdec_port #(.AW(AW), .FW(FW), .GATED_FIELD(GATED_FIELD)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .addr_i (addr_p[p]),
         .en_i   (en_p[p]),
         .pchg_i (pchg_p[p]),
         .wl_o   (wl_p[p])
      );
   end

endmodule

// File: tb/tb_dp_row_decoder.sv
module tb_dp_row_decoder;
   localparam int AW = 8;
   localparam int NR = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_a = '0, addr_b = '0;
   logic          en_a = 1'b1, en_b = 1'b1, pchg_a = 1'b0, pchg_b = 1'b0;
   logic [NR-1:0] wl_a, wl_b;

   logic [NR-1:0] exp_a = '0, exp_b = '0;
   string         tag_a = "R1", tag_b = "R1";
   int            n_cmp = 0, n_bad = 0;
   bit            done = 1'b0;
   bit            sweep = 1'b0;

   always #10 clk = ~clk;

   dp_row_decoder dut (
      .clk(clk), .rst_n(rst_n),
      .addr_a(addr_a), .en_a(en_a), .pchg_a(pchg_a), .wl_a(wl_a),
      .addr_b(addr_b), .en_b(en_b), .pchg_b(pchg_b), .wl_b(wl_b)
   );

   function automatic logic [NR-1:0] model(input logic en, input logic pchg,
                                          input logic [AW-1:0] a);
      logic [NR-1:0] v;
      v = '0;
      if (en && !pchg) v[a] = 1'b1;
      return v;
   endfunction

   function automatic string tag_for(input logic en, input logic pchg,
                                     input logic same);
      if (pchg) return "R3";
      if (!en) return "R4";
      if (same) return "R7";
      return "R2";
   endfunction

   // Reference model: what each port must show after this edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_a <= '0; exp_b <= '0; tag_a <= "R1"; tag_b <= "R1";
      end else begin
         exp_a <= model(en_a, pchg_a, addr_a);
         exp_b <= model(en_b, pchg_b, addr_b);
         tag_a <= sweep ? "R5" : tag_for(en_a, pchg_a,
                  (addr_a == addr_b) && en_b && !pchg_b);
         tag_b <= sweep ? "R5" : tag_for(en_b, pchg_b,
                  (addr_a == addr_b) && en_a && !pchg_a);
      end
   end

   task automatic cmp_port(input string port, input string tag,
                           input logic [NR-1:0] act, input logic [NR-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s port %s: act=%h exp=%h", tag, port, act, exp);
      end
      n_cmp++;
      if ($countones(act) > 1) begin
         n_bad++;
         $display("FAIL R6 port %s: act ones=%0d exp<=1", port, $countones(act));
      end
   endtask

   task automatic step(input logic [AW-1:0] aa, input logic ea, input logic pa,
                       input logic [AW-1:0] ab, input logic eb, input logic pb);
      @(negedge clk);
      cmp_port("A", tag_a, wl_a, exp_a);
      cmp_port("B", tag_b, wl_b, exp_b);
      addr_a = aa; en_a = ea; pchg_a = pa;
      addr_b = ab; en_b = eb; pchg_b = pb;
   endtask

   initial begin
      // R1: active inputs held during reset must not open any row
      addr_a = 8'd17; addr_b = 8'd200;
      repeat (3) step(8'd17, 1'b1, 1'b0, 8'd200, 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: every address on both ports, opposite directions
      sweep = 1'b1;
      for (int i = 0; i < NR; i++) begin
         step(AW'(i), 1'b1, 1'b0, AW'(NR - 1 - i), 1'b1, 1'b0);
      end
      step(8'd0, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
      sweep = 1'b0;

      // R7: both ports on the same row
      for (int i = 0; i < 24; i++) begin
         step(AW'(i * 11), 1'b1, 1'b0, AW'(i * 11), 1'b1, 1'b0);
      end

      // R3: precharge on one port while the other keeps reading
      for (int i = 0; i < 40; i++) begin
         step(AW'(i * 7), 1'b1, (i % 2) == 0, AW'(i * 7), 1'b1, 1'b0);
      end
      for (int i = 0; i < 20; i++) begin
         step(AW'(i * 5), 1'b1, 1'b0, AW'(i * 13), 1'b1, 1'b1);
      end

      // R4: disabled port, including enable low with precharge low
      for (int i = 0; i < 40; i++) begin
         step(AW'(i * 3), (i % 3) != 0, 1'b0, AW'(255 - i), (i % 2) == 0, 1'b0);
      end

      // Random mix of all input combinations
      for (int i = 0; i < 600; i++) begin
         step(AW'($urandom), ($urandom % 4) != 0, ($urandom % 3) == 0,
              AW'($urandom), ($urandom % 4) != 0, ($urandom % 3) == 0);
      end

      step(8'd0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1);
      step(8'd0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule